// File: doc/BRIEF.md
# Accumulator Register-Reference Unit

This block holds a 16-bit accumulator together with a one-bit extend flag that works as the accumulator's seventeenth bit. While the sequencer raises the register-execute strobe, the unit decodes the low twelve bits of the instruction register as a one-hot field of micro-operations. These operations clear, complement, rotate or increment the accumulator and the extend flag, and test them for a conditional skip or a halt.

When the strobe is low, the sequencer can load the accumulator from a data word. The load can be a bitwise AND, an add that captures the carry in the extend flag, a plain copy, or a character input that replaces only the low byte. The skip and halt requests are combinational, so the sequencer can act on them at the same clock edge that updates the registers.

Top module: `acc_regref_unit`

## Requirements
- R1: A synchronous active-low reset clears the accumulator and the extend flag to 0 at the next rising edge.
- R2: With the strobe high, ir_lo bit 11 clears the accumulator and ir_lo bit 10 clears the extend flag, at the next edge.
- R3: With the strobe high, ir_lo bit 9 inverts every accumulator bit and ir_lo bit 8 inverts the extend flag.
- R4: ir_lo bit 7 rotates the 17-bit pair right. The extend flag enters accumulator bit 15 and accumulator bit 0 becomes the new extend flag.
- R5: ir_lo bit 6 rotates the pair left. The extend flag enters accumulator bit 0 and accumulator bit 15 becomes the new extend flag.
- R6: ir_lo bit 5 adds 1 to the accumulator modulo 2^16 and leaves the extend flag unchanged.
- R7: In the strobe cycle, skip_req is high when any of these tests is selected and true: bit 4 (accumulator bit 15 is 0), bit 3 (accumulator bit 15 is 1), bit 2 (accumulator is zero), bit 1 (extend flag is 0). The tests use the values that bits 11 to 5 produce. skip_req is low whenever the strobe is low.
- R8: halt_req is high exactly when the strobe is high and ir_lo bit 0 is set.
- R9: When several bits are set, the operations apply in order from bit 11 down to bit 5, each acting on the result of the previous one, and all take effect in a single update.
- R10: With the strobe low and ld_en high, ld_sel selects the load. 0 gives AND with ld_data. 1 gives ADD, where the extend flag takes the carry out of bit 15. 2 copies ld_data. 3 replaces accumulator bits 7:0 with ld_data bits 7:0 and keeps bits 15:8. Only ADD changes the extend flag.
- R11: With neither the strobe nor ld_en high, the accumulator and the extend flag hold. The strobe takes precedence over ld_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_lo | input | 12 | One-hot micro-operation field of the instruction |
| rr_exec | input | 1 | Register-execute strobe |
| ld_en | input | 1 | Load request from the sequencer |
| ld_sel | input | 2 | Load kind: 0 AND, 1 ADD, 2 copy, 3 low-byte input |
| ld_data | input | 16 | Load operand |
| ac | output | 16 | Accumulator |
| e | output | 1 | Extend flag |
| skip_req | output | 1 | Request to advance the program counter once more |
| halt_req | output | 1 | Request to clear the run flip-flop |

## Verification
skip_req and halt_req are due in the same cycle as the strobe, before the rising edge. The accumulator and the extend flag are due one rising edge after the strobe or load. The bench drives inputs on the falling edge and compares the two requests against its model 1 ns later. It compares the registers at the following falling edge, after the update. Directed cases cover every single-bit code, the wrap of the increment, carry-out on ADD, the low-byte input, a strobe that coincides with a load, and combined codes. A long stretch of random codes follows.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the accumulator unit.
// Assumes the micro-operation field is 12 bits wide and one-hot by convention.
package acc_pkg;
    localparam int IR_LO_W = 12;
    localparam int BIT_CLR_AC  = 11;
    localparam int BIT_CLR_E   = 10;
    localparam int BIT_INV_AC  = 9;
    localparam int BIT_INV_E   = 8;
    localparam int BIT_ROT_R   = 7;
    localparam int BIT_ROT_L   = 6;
    localparam int BIT_INCR    = 5;
    localparam int BIT_T_POS   = 4;
    localparam int BIT_T_NEG   = 3;
    localparam int BIT_T_ZERO  = 2;
    localparam int BIT_T_EZERO = 1;
    localparam int BIT_HALT    = 0;
    localparam int N_MODIFY    = BIT_CLR_AC - BIT_INCR + 1;

    typedef enum logic [1:0] {
        LD_AND  = 2'd0,
        LD_ADD  = 2'd1,
        LD_COPY = 2'd2,
        LD_CHAR = 2'd3
    } ld_kind_e;
endpackage

// File: rtl/acc_microop_chain.sv
`timescale 1ns/1ps
// Module: acc_microop_chain
// Applies the modifying micro-operations (bits 11..5) in descending bit order.
// Each stage acts on the previous stage's result. The module is purely combinational.
// Assumes the caller gates the result with the execute strobe.
module acc_microop_chain
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [IR_LO_W-1:0] ir_lo,
    input  logic [DATA_W-1:0]  ac_in,
    input  logic               e_in,
    output logic [DATA_W-1:0]  ac_out,
    output logic               e_out
);
    logic [DATA_W-1:0] ac_s [0:N_MODIFY];
    logic              e_s  [0:N_MODIFY];

    assign ac_s[0] = ac_in;
    assign e_s[0]  = e_in;

    for (genvar g = 0; g < N_MODIFY; g++) begin : g_stage
        localparam int B = BIT_CLR_AC - g;
        if (B == BIT_CLR_AC) begin : g_clr_ac
            // Stage purpose: clear the accumulator.
            assign ac_s[g+1] = ir_lo[B] ? '0 : ac_s[g];
            assign e_s[g+1]  = e_s[g];
        end else if (B == BIT_CLR_E) begin : g_clr_e
            // Stage purpose: clear the extend flag.
            assign ac_s[g+1] = ac_s[g];
            assign e_s[g+1]  = ir_lo[B] ? 1'b0 : e_s[g];
        end else if (B == BIT_INV_AC) begin : g_inv_ac
            // Stage purpose: invert the accumulator.
            assign ac_s[g+1] = ir_lo[B] ? ~ac_s[g] : ac_s[g];
            assign e_s[g+1]  = e_s[g];
        end else if (B == BIT_INV_E) begin : g_inv_e
            // Stage purpose: invert the extend flag.
            assign ac_s[g+1] = ac_s[g];
            assign e_s[g+1]  = ir_lo[B] ? ~e_s[g] : e_s[g];
        end else if (B == BIT_ROT_R) begin : g_rot_r
            // Stage purpose: rotate the {e, ac} pair right by one.
            assign ac_s[g+1] = ir_lo[B] ? {e_s[g], ac_s[g][DATA_W-1:1]} : ac_s[g];
            assign e_s[g+1]  = ir_lo[B] ? ac_s[g][0] : e_s[g];
        end else if (B == BIT_ROT_L) begin : g_rot_l
            // Stage purpose: rotate the {e, ac} pair left by one.
            assign ac_s[g+1] = ir_lo[B] ? {ac_s[g][DATA_W-2:0], e_s[g]} : ac_s[g];
            assign e_s[g+1]  = ir_lo[B] ? ac_s[g][DATA_W-1] : e_s[g];
        end else begin : g_incr
            // Stage purpose: increment the accumulator modulo 2^DATA_W.
            assign ac_s[g+1] = ir_lo[B] ? ac_s[g] + 1'b1 : ac_s[g];
            assign e_s[g+1]  = e_s[g];
        end
    end

    assign ac_out = ac_s[N_MODIFY];
    assign e_out  = e_s[N_MODIFY];
endmodule

// File: rtl/acc_skip_test.sv
`timescale 1ns/1ps
// Module: acc_skip_test
// ORs the four selected condition tests into one raw skip flag.
// Assumes the inputs are the values after the modifying stages.
module acc_skip_test
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [IR_LO_W-1:0] ir_lo,
    input  logic [DATA_W-1:0]  ac_val,
    input  logic               e_val,
    output logic               skip_raw
);
    logic sign;
    logic is_zero;

    assign sign    = ac_val[DATA_W-1];
    assign is_zero = (ac_val == '0);

    // Combine the selected tests.
    always_comb begin
        skip_raw = (ir_lo[BIT_T_POS]   & ~sign)
                 | (ir_lo[BIT_T_NEG]   &  sign)
                 | (ir_lo[BIT_T_ZERO]  &  is_zero)
                 | (ir_lo[BIT_T_EZERO] & ~e_val);
    end
endmodule

// File: rtl/acc_load_unit.sv
`timescale 1ns/1ps
// Module: acc_load_unit
// Forms the accumulator and extend flag that a sequencer load would produce.
// Assumes the caller decides whether the load is taken. Only ADD alters the flag.
module acc_load_unit
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  ld_kind_e           ld_kind,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic [DATA_W-1:0]  ac_in,
    input  logic               e_in,
    output logic [DATA_W-1:0]  ac_ld,
    output logic               e_ld
);
    logic [DATA_W:0] sum;

    assign sum = {1'b0, ac_in} + {1'b0, ld_data};

    // Select the load result.
    always_comb begin
        ac_ld = ac_in;
        e_ld  = e_in;
        unique case (ld_kind)
            LD_AND:  ac_ld = ac_in & ld_data;
            LD_ADD:  begin
                ac_ld = sum[DATA_W-1:0];
                e_ld  = sum[DATA_W];
            end
            LD_COPY: ac_ld = ld_data;
            LD_CHAR: ac_ld = {ac_in[DATA_W-1:CHAR_W], ld_data[CHAR_W-1:0]};
            default: ac_ld = ac_in;
        endcase
    end
endmodule

// File: rtl/acc_regref_unit.sv
`timescale 1ns/1ps
// Module: acc_regref_unit (top)
// Holds the accumulator and extend flag. Executes the one-hot micro-operations
// under rr_exec and accepts sequencer loads otherwise.
// Assumes rr_exec lasts one cycle per instruction and takes precedence over ld_en.
module acc_regref_unit
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IR_LO_W-1:0] ir_lo,
    input  logic               rr_exec,
    input  logic               ld_en,
    input  logic [1:0]         ld_sel,
    input  logic [DATA_W-1:0]  ld_data,
    output logic [DATA_W-1:0]  ac,
    output logic               e,
    output logic               skip_req,
    output logic               halt_req
);
    logic [DATA_W-1:0] ac_q, ac_chain, ac_ld;
    logic              e_q, e_chain, e_ld, skip_raw;
    ld_kind_e          ld_kind;

    assign ld_kind = ld_kind_e'(ld_sel);

    acc_microop_chain #(.DATA_W(DATA_W)) u_chain (
        .ir_lo  (ir_lo),
        .ac_in  (ac_q),
        .e_in   (e_q),
        .ac_out (ac_chain),
        .e_out  (e_chain)
    );

    acc_skip_test #(.DATA_W(DATA_W)) u_skip (
        .ir_lo    (ir_lo),
        .ac_val   (ac_chain),
        .e_val    (e_chain),
        .skip_raw (skip_raw)
    );

    acc_load_unit #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_load (
        .ld_kind (ld_kind),
        .ld_data (ld_data),
        .ac_in   (ac_q),
        .e_in    (e_q),
        .ac_ld   (ac_ld),
        .e_ld    (e_ld)
    );

    // Register update: reset, then execute, then load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else if (rr_exec) begin
            ac_q <= ac_chain;
            e_q  <= e_chain;
        end else if (ld_en) begin
            ac_q <= ac_ld;
            e_q  <= e_ld;
        end
    end

    assign ac       = ac_q;
    assign e        = e_q;
    assign skip_req = rr_exec & skip_raw;
    assign halt_req = rr_exec & ir_lo[BIT_HALT];

    // Assertions guarding the register update and request outputs.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_exec && !ld_en) |=> ($stable(ac) && $stable(e)));
    p_clear_ac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_exec && ir_lo[BIT_CLR_AC] && ir_lo[BIT_INV_AC:BIT_INCR] == '0) |=> (ac == '0));
    p_rot_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_exec && ir_lo == 12'h080) |=>
        (ac == {$past(e), $past(ac[DATA_W-1:1])} && e == $past(ac[0])));
    p_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_exec && ir_lo == 12'h020) |=> (ac == DATA_W'($past(ac) + 1'b1) && $stable(e)));
    p_skip_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rr_exec |-> !skip_req);
    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (rr_exec && ir_lo[BIT_HALT]));
    p_char_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_exec && ld_en && ld_sel == 2'd3) |=> $stable(ac[DATA_W-1:CHAR_W]));
    p_e_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_exec && ld_en && ld_sel != 2'd1) |=> $stable(e));
endmodule

// File: tb/test_acc_regref_unit.sv
`timescale 1ns/1ps
module test_acc_regref_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ir_lo = '0;
    logic        rr_exec = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] ac;
    logic        e, skip_req, halt_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_ac = '0;
    logic        m_e = 1'b0;

    always #2 clk = ~clk;

    acc_regref_unit i_acc_regref_unit (
        .clk(clk), .rst_n(rst_n), .ir_lo(ir_lo), .rr_exec(rr_exec),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .ac(ac), .e(e), .skip_req(skip_req), .halt_req(halt_req)
    );

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // One cycle: check state, drive, check requests, advance the model.
    task automatic step(input string tag, input logic rst, input logic ex,
                        input logic [11:0] ir, input logic le,
                        input logic [1:0] sel, input logic [15:0] d);
        logic [15:0] a; logic ee; logic sk; logic [16:0] s;
        @(negedge clk);
        check({tag, " state"}, {m_e, ac === ac ? ac : 16'hxxxx}, {m_e, m_ac});
        check({tag, " e"}, {16'h0, e}, {16'h0, m_e});
        rst_n = rst; rr_exec = ex; ir_lo = ir; ld_en = le; ld_sel = sel; ld_data = d;
        a = m_ac; ee = m_e;
        if (ir[11]) a = '0;
        if (ir[10]) ee = 1'b0;
        if (ir[9])  a = ~a;
        if (ir[8])  ee = ~ee;
        if (ir[7])  {a, ee} = {ee, a};
        if (ir[6])  {ee, a} = {a, ee};
        if (ir[5])  a = a + 16'd1;
        sk = ex && ((ir[4] && !a[15]) || (ir[3] && a[15]) ||
                    (ir[2] && a == 16'd0) || (ir[1] && !ee));
        #1;
        check({tag, " skip R7"}, {16'h0, skip_req}, {16'h0, sk});
        check({tag, " halt R8"}, {16'h0, halt_req}, {16'h0, ex && ir[0]});
        @(posedge clk);
        if (!rst) begin
            m_ac = '0; m_e = 1'b0;
        end else if (ex) begin
            m_ac = a; m_e = ee;
        end else if (le) begin
            case (sel)
                2'd0: m_ac = m_ac & d;
                2'd1: begin s = {1'b0, m_ac} + {1'b0, d}; m_ac = s[15:0]; m_e = s[16]; end
                2'd2: m_ac = d;
                default: m_ac = {m_ac[15:8], d[7:0]};
            endcase
        end
    endtask

    task automatic exec_op(input string tag, input logic [11:0] ir);
        step(tag, 1'b1, 1'b1, ir, 1'b0, 2'd0, 16'h0);
    endtask

    task automatic load(input string tag, input logic [1:0] sel, input logic [15:0] d);
        step(tag, 1'b1, 1'b0, 12'h0, 1'b1, sel, d);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        step("R1 reset", 1'b0, 1'b0, 12'h0, 1'b0, 2'd0, 16'h0);
        step("R1 reset", 1'b0, 1'b1, 12'hFFF, 1'b1, 2'd2, 16'hFFFF);
        load("R10 copy", 2'd2, 16'h1234);
        step("R11 idle", 1'b1, 1'b0, 12'h800, 1'b0, 2'd2, 16'h5555);
        exec_op("R2 clear ac", 12'h800);
        load("R10 copy", 2'd2, 16'h8001);
        exec_op("R3 invert e", 12'h100);
        exec_op("R2 clear e", 12'h400);
        exec_op("R3 invert ac", 12'h200);
        exec_op("R3 invert ac", 12'h200);
        exec_op("R4 rot right", 12'h080);
        exec_op("R4 rot right", 12'h080);
        exec_op("R5 rot left", 12'h040);
        exec_op("R5 rot left", 12'h040);
        exec_op("R5 rot left", 12'h040);
        load("R10 copy", 2'd2, 16'hFFFF);
        exec_op("R6 incr wrap", 12'h020);
        exec_op("R6 incr", 12'h020);
        exec_op("R7 pos", 12'h010);
        exec_op("R7 neg", 12'h008);
        exec_op("R7 zero", 12'h004);
        exec_op("R7 ezero", 12'h002);
        exec_op("R3 invert e", 12'h100);
        exec_op("R7 ezero", 12'h002);
        load("R10 copy", 2'd2, 16'h0000);
        exec_op("R7 zero", 12'h004);
        exec_op("R7 pos", 12'h010);
        exec_op("R7 neg", 12'h008);
        exec_op("R8 halt", 12'h001);
        exec_op("R9 clear+incr", 12'h820);
        exec_op("R9 invert+incr", 12'h220);
        exec_op("R9 clear+zero test", 12'h804);
        exec_op("R9 clr e+inv e+rot", 12'h580);
        load("R10 copy", 2'd2, 16'hF00F);
        load("R10 add carry", 2'd1, 16'h1FF1);
        load("R10 add", 2'd1, 16'h0001);
        load("R10 and", 2'd0, 16'h0FF0);
        load("R10 char", 2'd3, 16'hABCD);
        step("R11 exec over load", 1'b1, 1'b1, 12'h200, 1'b1, 2'd2, 16'h7777);
        step("R11 idle", 1'b1, 1'b0, 12'h020, 1'b0, 2'd1, 16'hFFFF);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:30] == 2'd0)
                load("R10 random load", r[29:28], r[15:0]);
            else if (r[31:29] == 3'd2)
                step("R11 random idle", 1'b1, 1'b0, r[27:16], 1'b0, r[1:0], r[15:0]);
            else
                exec_op("R9 random exec", r[27:16] & {r[15:4]});
        end
        load("R10 copy", 2'd2, 16'hBEEF);
        step("R1 reset mid-run", 1'b0, 1'b0, 12'h0, 1'b0, 2'd0, 16'h0);
        step("R1 after reset", 1'b1, 1'b0, 12'h0, 1'b0, 2'd0, 16'h0);
        @(negedge clk);
        check("R1 final state", {e, ac}, {m_e, m_ac});
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule